// File: doc/BRIEF.md
# Multi-Stage Arm and Trigger Sequencer

This block turns a vector of go requests into a single trigger pulse, but only once the requests have come in the expected order. The go vector is `GO_W` bits wide, one bit by default. Bit `GO_W-1` arms the first stage, each lower bit arms the next stage, and bit 0 fires the trigger from the last armed stage. A one-clock `fire` pulse starts whatever downstream action the chip attaches to it.

The current stage is reported on a one-hot `stage` vector that is `GO_W` bits wide. Its most-significant bit marks the idle stage and its least-significant bit marks the final armed stage. In the stage that has bit k set, only go bit k moves the sequence on. When `GO_W` is 1 the sequencer has only its idle stage, and go fires the trigger directly.

Top module: `arm_trigger_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next cycle shows `stage` equal to the idle code (only bit `GO_W-1` set) and `fire` low, whatever `go_vec` holds.
- R2: `stage` always has exactly one of its `GO_W` bits set. Bit `GO_W-1` means idle and bit 0 means the final armed stage.
- R3: In a stage with bit k set, where k > 0, a high `go_vec[k]` at a clock edge moves `stage` to bit k-1 in the next cycle, with `fire` low.
- R4: In the stage with bit 0 set, a high `go_vec[0]` at a clock edge raises `fire` for exactly one cycle. In that same cycle `stage` already shows the idle code.
- R5: In a stage with bit k set, go bits other than bit k are ignored. When `go_vec[k]` is low, `stage` and `fire` stay as they were.
- R6: During the cycle in which `fire` is high, the whole of `go_vec` is ignored. In the next cycle `stage` is still idle and `fire` is low, even if go bits stay asserted.
- R7: With `GO_W` = 1, `stage` is the single idle bit. A high `go_vec[0]` fires the trigger straight from idle, and a held go produces a pulse every second cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| go_vec | input | GO_W | Ordered go requests; the top bit arms first, bit 0 fires |
| fire | output | 1 | One-clock trigger pulse |
| stage | output | GO_W | One-hot stage; the top bit is idle, bit 0 is the final armed stage |

## Verification
The assertions take for granted that `rst` is high at the first rising edge and that `go_vec` and `rst` never carry unknown values at a clock edge. They also assume reset is the only way back to idle other than a trigger. The stimulus starts in reset and changes inputs only on the falling edge, so every value is settled and known at the sampling edge. It then walks the go bits in order, out of order, all at once and held, and asserts reset in the middle of an armed sequence.

// File: rtl/arm_seq_pkg.sv
package arm_seq_pkg;

    // Action chosen by the next-stage logic for the coming edge
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_STEP = 2'd1,
        ACT_FIRE = 2'd2
    } seq_act_e;

    // Idle code: only the top bit of a w-bit stage vector set
    function automatic logic [31:0] idle_word(input int w);
        idle_word = 32'd1 << (w - 1);
    endfunction

endpackage

// File: rtl/arm_seq_next.sv
module arm_seq_next
    import arm_seq_pkg::*;
#(
    parameter int W = 1
) (
    input  logic [W-1:0] stage,
    input  logic [W-1:0] go_vec,
    input  logic         fire_q,
    output logic [W-1:0] stage_d,
    output seq_act_e     act
);

    logic [W-1:0] hit;

    // A stage bit counts only with its own go bit, and never in a fire cycle
    assign hit = stage & go_vec & {W{~fire_q}};

    for (genvar k = 0; k < W; k++) begin : g_bit
        if (k == W - 1) begin : g_top
            assign stage_d[k] = (stage[k] & ~hit[k]) | hit[0];
        end else begin : g_mid
            assign stage_d[k] = (stage[k] & ~hit[k]) | hit[k+1];
        end
    end

    always_comb begin
        if (hit[0]) begin
            act = ACT_FIRE;
        end else if (|hit) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end

endmodule

// File: rtl/arm_seq_state.sv
module arm_seq_state
    import arm_seq_pkg::*;
#(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] stage_d,
    input  seq_act_e     act,
    output logic [W-1:0] stage_q,
    output logic         fire_q
);

    localparam logic [31:0]  IDLE_WIDE = idle_word(W);
    localparam logic [W-1:0] IDLE      = IDLE_WIDE[W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= IDLE;
            fire_q  <= 1'b0;
        end else begin
            fire_q <= (act == ACT_FIRE);
            if (act != ACT_HOLD) begin
                stage_q <= stage_d;
            end
        end
    end

endmodule

// File: rtl/arm_trigger_seq.sv
module arm_trigger_seq
    import arm_seq_pkg::*;
#(
    parameter int GO_W = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [GO_W-1:0] go_vec,
    output logic            fire,
    output logic [GO_W-1:0] stage
);

    logic [GO_W-1:0] stage_d;
    seq_act_e        act;

    arm_seq_next #(.W(GO_W)) u_next (
        .stage   (stage),
        .go_vec  (go_vec),
        .fire_q  (fire),
        .stage_d (stage_d),
        .act     (act)
    );

    arm_seq_state #(.W(GO_W)) u_state (
        .clk     (clk),
        .rst     (rst),
        .stage_d (stage_d),
        .act     (act),
        .stage_q (stage),
        .fire_q  (fire)
    );

endmodule

// File: rtl/arm_trigger_seq_chk.sv
module arm_trigger_seq_chk #(
    parameter int W = 1
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] go_vec,
    input logic         fire,
    input logic [W-1:0] stage
);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (stage[W-1] && $countones(stage) == 1 && !fire));

    // R2
    stage_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(stage) == 1);

    // R4
    fire_single_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> !fire);

    // R4
    fire_at_idle_chk: assert property (@(posedge clk) disable iff (rst)
        fire |-> stage[W-1]);

    // R4
    fire_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (stage[0] && go_vec[0] && !fire) |=> fire);

    // R5
    ignore_other_chk: assert property (@(posedge clk) disable iff (rst)
        (!fire && !(|(stage & go_vec))) |=> ($stable(stage) && !fire));

    // R6
    cooldown_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> ($stable(stage) && !fire));

    for (genvar k = 1; k < W; k++) begin : g_adv
        // R3
        advance_chk: assert property (@(posedge clk) disable iff (rst)
            (!fire && stage[k] && go_vec[k]) |=> (stage[k-1] && !fire));
    end

endmodule

bind arm_trigger_seq arm_trigger_seq_chk #(.W(GO_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .go_vec (go_vec),
    .fire   (fire),
    .stage  (stage)
);

// File: tb/arm_trigger_seq_test.sv
module arm_trigger_seq_test;

    typedef struct {
        logic [6:0] val;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] go4 = 4'b0;
    logic       go1 = 1'b0;
    logic       fire4, fire1;
    logic [3:0] stage4;
    logic       stage1;

    exp_t q[$];
    int   total = 0;
    int   bad   = 0;
    bit   finished = 0;

    int idx4  = 3;
    bit cool4 = 0;
    bit cool1 = 0;

    arm_trigger_seq #(.GO_W(4)) uut (
        .clk(clk), .rst(rst), .go_vec(go4), .fire(fire4), .stage(stage4)
    );

    arm_trigger_seq #(.GO_W(1)) uut1 (
        .clk(clk), .rst(rst), .go_vec(go1), .fire(fire1), .stage(stage1)
    );

    always #2 clk = ~clk;

    // Driver: apply inputs on the falling edge and push the expected result
    task automatic step(input logic r, input logic [3:0] g4, input logic g1,
                        input string tag);
        exp_t e;
        bit   f4, f1;
        @(negedge clk);
        rst = r;
        go4 = g4;
        go1 = g1;
        f4 = 0;
        f1 = 0;
        if (r) begin
            idx4  = 3;
            cool4 = 0;
            cool1 = 0;
        end else begin
            if (cool4) begin
                cool4 = 0;
            end else if (g4[idx4]) begin
                if (idx4 == 0) begin
                    f4   = 1;
                    idx4 = 3;
                end else begin
                    idx4 = idx4 - 1;
                end
            end
            cool4 = f4;
            f1    = !cool1 && g1;
            cool1 = f1;
        end
        e.val = {f4, 4'(4'b1 << idx4), f1, 1'b1};
        e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare just after each rising edge
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            logic [6:0] act;
            e   = q.pop_front();
            act = {fire4, stage4, fire1, stage1};
            total++;
            if (act !== e.val) begin
                bad++;
                $display("FAIL %s: actual %b expected %b", e.tag, act, e.val);
            end
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - bad, total);
            $finish;
        end
    end

    initial begin
        step(1, 4'b0000, 0, "R1 R2 reset");
        step(1, 4'b1111, 1, "R1 reset ignores go");
        step(0, 4'b0111, 0, "R5 idle wrong bits");
        step(0, 4'b1000, 0, "R3 arm top");
        step(0, 4'b1011, 0, "R5 stage2 wrong bits");
        step(0, 4'b0100, 0, "R3 stage2 to 1");
        step(0, 4'b0010, 0, "R3 stage1 to 0");
        step(0, 4'b1110, 0, "R5 final stage wrong bits");
        step(0, 4'b0001, 0, "R4 fire");
        step(0, 4'b0001, 0, "R6 go ignored in fire cycle");
        step(0, 4'b0001, 0, "R5 idle go0 ignored");
        step(0, 4'b1111, 0, "R3 all ones arm");
        step(0, 4'b1111, 0, "R3 all ones step");
        step(0, 4'b1111, 0, "R3 all ones to final");
        step(0, 4'b1111, 0, "R4 all ones fire");
        step(0, 4'b1111, 0, "R6 all ones held");
        step(0, 4'b1111, 0, "R3 rearm after fire");
        step(0, 4'b0100, 0, "R3 to stage1");
        step(1, 4'b1111, 0, "R1 reset mid sequence");
        step(0, 4'b0000, 1, "R7 single bit fire");
        step(0, 4'b0000, 1, "R7 held go gap");
        step(0, 4'b0000, 1, "R7 held go refire");
        step(0, 4'b0000, 0, "R7 go low idle");
        step(0, 4'b0000, 0, "R5 quiet");
        @(negedge clk);
        @(negedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", total - bad, total);
        $finish;
    end

endmodule